// File: doc/BRIEF.md
# Scan-Cycle Watchdog Timer

This block measures how long each pass of a cyclic control program takes and raises a major fault when a pass runs too long. A free-running 10 ms strobe from elsewhere in the chip advances a scan tick counter. A scan-boundary pulse marks the end of one pass and the start of the next. The count is compared with a programmable limit byte, also kept in 10 ms units. When the count reaches the limit, a sticky fault flag and a fixed 16-bit fault code are latched.

The limit byte can be read and written through a simple write strobe and data byte. Its current value is always visible on an output. Values written outside the legal window are pulled to the nearest legal bound. A single fault-clear input lets the surrounding logic acknowledge the fault and restart timing. While a fault is latched, the counter holds still, so the count at the moment of the trip stays readable.

Top module: `scan_wdt`

## Requirements
- R1: After reset the limit output reads 10 (100 ms), the scan count reads 0, the fault flag is low and the fault code reads 0x0000.
- R2: A write of a value from 2 to 250 is stored unchanged, and the limit output shows it on the cycle after the write strobe.
- R3: A write below 2 stores 2, and a write above 250 stores 250, so the limit output always lies in the range 2 to 250.
- R4: During a scan, with no fault, no fault-clear and the count not equal to the limit, each cycle with the tick strobe high raises the count by exactly one on the next cycle; cycles without a tick leave it unchanged.
- R5: A scan-boundary pulse sets the count to 0 on the next cycle, also when a tick arrives in the same cycle.
- R6: When the count equals the limit, the fault flag is high on the next cycle and the fault code reads 0x0022; the count does not advance past the limit.
- R7: Once the fault is set, it stays set until reset or fault-clear, and ticks no longer change the count (a scan-boundary pulse still sets it to 0).
- R8: A fault-clear pulse makes the fault flag low, the code 0x0000 and the count 0 on the next cycle, and it takes precedence over a trip in the same cycle.
- R9: The fault code reads 0x0022 exactly when the fault flag is high, and 0x0000 otherwise; no fault is raised while scans end before the count reaches the limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle 10 ms time strobe |
| scan_end_i | input | 1 | One-cycle scan boundary pulse |
| lim_wr_i | input | 1 | Limit byte write strobe |
| lim_wdata_i | input | 8 | Limit byte write data, in 10 ms units |
| fault_clr_i | input | 1 | Fault acknowledge and restart |
| scan_cnt_o | output | 8 | Ticks elapsed in the current scan |
| limit_o | output | 8 | Current watchdog limit (read-back) |
| fault_o | output | 1 | Sticky major-fault flag |
| fault_code_o | output | 16 | Fault code, 0x0022 on a watchdog trip |

## Verification
The counter is driven with sparse ticks, back-to-back ticks, and scans that end exactly one tick short of the limit. These patterns separate an off-by-one in the comparison from a correct trip. Boundary pulses that coincide with a tick show whether restart wins over increment. Ticks that continue after a trip expose a counter that fails to freeze. A fault-clear issued in the same cycle as a trip shows the clear priority. Limit writes at 0, 1, 2, 250, 251 and 255 pin down both clamp edges and the legal values next to them. A trip at the reset limit of 10 confirms the default.

// File: rtl/scan_wdt_pkg.sv
package scan_wdt_pkg;
  localparam int unsigned TICK_W      = 8;
  localparam int unsigned CODE_W      = 16;
  localparam int unsigned LIM_DEFAULT = 10;
  localparam int unsigned LIM_LOW     = 2;
  localparam int unsigned LIM_HIGH    = 250;
  localparam logic [CODE_W-1:0] TRIP_CODE = 16'h0022;
endpackage

// File: rtl/wdt_limit_reg.sv
module wdt_limit_reg #(
  parameter int unsigned W       = 8,
  parameter int unsigned RST_VAL = 10,
  parameter int unsigned LOW     = 2,
  parameter int unsigned HIGH    = 250
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lim
);
  localparam logic [W-1:0] LOW_V  = W'(LOW);
  localparam logic [W-1:0] HIGH_V = W'(HIGH);
  localparam logic [W-1:0] RST_V  = W'(RST_VAL);

  logic [W-1:0] lo_fixed;
  logic [W-1:0] clamped;
  logic [W-1:0] lim_d;
  logic [W-1:0] lim_q;

  // Lower bound stage: omitted when the floor is zero.
  generate
    if (LOW == 0) begin : g_no_floor
      assign lo_fixed = wdata;
    end else begin : g_floor
      assign lo_fixed = (wdata < LOW_V) ? LOW_V : wdata;
    end
  endgenerate

  always_comb begin
    clamped = (lo_fixed > HIGH_V) ? HIGH_V : lo_fixed;
  end

  always_comb begin
    lim_d = lim_q;
    if (wr_en) begin
      lim_d = clamped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= RST_V;
    end else begin
      lim_q <= lim_d;
    end
  end

  assign lim = lim_q;
endmodule

// File: rtl/wdt_scan_counter.sv
module wdt_scan_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         step,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;
  logic [W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (restart) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdt_fault_latch.sv
module wdt_fault_latch #(
  parameter int unsigned      CODE_W = 16,
  parameter logic [CODE_W-1:0] CODE  = 16'h0022
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trip,
  input  logic              clr,
  output logic              fault,
  output logic [CODE_W-1:0] code
);
  logic              flt_d, flt_q;
  logic [CODE_W-1:0] code_d, code_q;

  always_comb begin
    flt_d  = flt_q;
    code_d = code_q;
    if (clr) begin
      flt_d  = 1'b0;
      code_d = '0;
    end else if (trip) begin
      flt_d  = 1'b1;
      code_d = CODE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q  <= 1'b0;
      code_q <= '0;
    end else begin
      flt_q  <= flt_d;
      code_q <= code_d;
    end
  end

  assign fault = flt_q;
  assign code  = code_q;
endmodule

// File: rtl/scan_wdt.sv
module scan_wdt
  import scan_wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = TICK_W,
  parameter int unsigned LIM_RST = LIM_DEFAULT,
  parameter int unsigned LIM_MIN = LIM_LOW,
  parameter int unsigned LIM_MAX = LIM_HIGH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              scan_end_i,
  input  logic              lim_wr_i,
  input  logic [CNT_W-1:0]  lim_wdata_i,
  input  logic              fault_clr_i,
  output logic [CNT_W-1:0]  scan_cnt_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic              fault_o,
  output logic [CODE_W-1:0] fault_code_o
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             at_limit;
  logic             fault;
  logic             cnt_restart;
  logic             cnt_step;

  assign at_limit    = (cnt == lim);
  assign cnt_restart = scan_end_i | fault_clr_i;
  assign cnt_step    = tick_i & ~fault & ~at_limit;

  wdt_limit_reg #(
    .W       (CNT_W),
    .RST_VAL (LIM_RST),
    .LOW     (LIM_MIN),
    .HIGH    (LIM_MAX)
  ) u_limit (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (lim_wr_i),
    .wdata (lim_wdata_i),
    .lim   (lim)
  );

  wdt_scan_counter #(
    .W (CNT_W)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (cnt_restart),
    .step    (cnt_step),
    .cnt     (cnt)
  );

  wdt_fault_latch #(
    .CODE_W (CODE_W),
    .CODE   (TRIP_CODE)
  ) u_fault (
    .clk   (clk),
    .rst_n (rst_n),
    .trip  (at_limit),
    .clr   (fault_clr_i),
    .fault (fault),
    .code  (fault_code_o)
  );

  assign scan_cnt_o = cnt;
  assign limit_o    = lim;
  assign fault_o    = fault;
endmodule

// File: rtl/scan_wdt_chk.sv
module scan_wdt_chk
  import scan_wdt_pkg::*;
#(
  parameter int unsigned CNT_W   = TICK_W,
  parameter int unsigned LIM_MIN = LIM_LOW,
  parameter int unsigned LIM_MAX = LIM_HIGH
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              scan_end_i,
  input logic              lim_wr_i,
  input logic [CNT_W-1:0]  lim_wdata_i,
  input logic              fault_clr_i,
  input logic [CNT_W-1:0]  scan_cnt_o,
  input logic [CNT_W-1:0]  limit_o,
  input logic              fault_o,
  input logic [CODE_W-1:0] fault_code_o
);
  a_r2_write_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_wr_i && lim_wdata_i >= CNT_W'(LIM_MIN) && lim_wdata_i <= CNT_W'(LIM_MAX))
      |=> (limit_o == $past(lim_wdata_i)));

  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_o >= CNT_W'(LIM_MIN)) && (limit_o <= CNT_W'(LIM_MAX)));

  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !fault_o && !fault_clr_i && !scan_end_i && scan_cnt_o != limit_o)
      |=> (scan_cnt_o == $past(scan_cnt_o) + CNT_W'(1)));

  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_end_i || fault_clr_i) |=> (scan_cnt_o == '0));

  a_r6_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_clr_i && scan_cnt_o == limit_o) |=> (fault_o && fault_code_o == TRIP_CODE));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !fault_clr_i) |=> fault_o);

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !fault_clr_i && !scan_end_i) |=> $stable(scan_cnt_o));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clr_i |=> (!fault_o && fault_code_o == '0));

  a_r9_code_match: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o ? (fault_code_o == TRIP_CODE) : (fault_code_o == '0));
endmodule

bind scan_wdt scan_wdt_chk #(
  .CNT_W   (CNT_W),
  .LIM_MIN (LIM_MIN),
  .LIM_MAX (LIM_MAX)
) u_chk (.*);

// File: tb/scan_wdt_bench.sv
module scan_wdt_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        scan_end_i = 1'b0;
  logic        lim_wr_i = 1'b0;
  logic [7:0]  lim_wdata_i = 8'd0;
  logic        fault_clr_i = 1'b0;
  logic [7:0]  scan_cnt_o;
  logic [7:0]  limit_o;
  logic        fault_o;
  logic [15:0] fault_code_o;

  int    n_run  = 0;
  int    n_fail = 0;
  int    cyc    = 0;
  bit    live   = 1'b0;
  bit    done   = 1'b0;
  string tag    = "R1";

  // Behavioural reference state.
  int m_cnt = 0;
  int m_lim = 10;
  bit m_flt = 1'b0;

  always #5 clk = ~clk;

  scan_wdt u_scan_wdt (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .scan_end_i   (scan_end_i),
    .lim_wr_i     (lim_wr_i),
    .lim_wdata_i  (lim_wdata_i),
    .fault_clr_i  (fault_clr_i),
    .scan_cnt_o   (scan_cnt_o),
    .limit_o      (limit_o),
    .fault_o      (fault_o),
    .fault_code_o (fault_code_o)
  );

  always @(posedge clk) begin
    int nc, nl;
    bit nf;
    if (!rst_n) begin
      m_cnt = 0; m_lim = 10; m_flt = 1'b0;
    end else begin
      nc = m_cnt; nl = m_lim; nf = m_flt;
      if (fault_clr_i) begin
        nf = 1'b0; nc = 0;
      end else begin
        if (m_cnt == m_lim) nf = 1'b1;
        if (scan_end_i) nc = 0;
        else if (tick_i && !m_flt && m_cnt != m_lim) nc = (m_cnt + 1) % 256;
      end
      if (lim_wr_i) begin
        if (lim_wdata_i < 2) nl = 2;
        else if (lim_wdata_i > 250) nl = 250;
        else nl = lim_wdata_i;
      end
      m_cnt = nc; m_lim = nl; m_flt = nf;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (live && rst_n) begin
      chk(tag, "scan_cnt", scan_cnt_o, m_cnt);
      chk(tag, "limit", limit_o, m_lim);
      chk(tag, "fault", fault_o, m_flt);
      chk("R9", "code", fault_code_o, m_flt ? 32'h22 : 0);
    end
  end

  task automatic step(bit t, bit se, bit clr);
    tick_i = t; scan_end_i = se; fault_clr_i = clr;
    @(negedge clk);
    tick_i = 1'b0; scan_end_i = 1'b0; fault_clr_i = 1'b0;
  endtask

  task automatic wr_lim(int v);
    lim_wr_i = 1'b1; lim_wdata_i = 8'(v);
    @(negedge clk);
    lim_wr_i = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset values
    chk("R1", "limit", limit_o, 10);
    chk("R1", "scan_cnt", scan_cnt_o, 0);
    chk("R1", "fault", fault_o, 0);
    chk("R1", "code", fault_code_o, 0);
    live = 1'b1;

    // R1: trip at the default limit of 10 ticks
    tag = "R1";
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 1'b0);
    chk("R1", "fault at default limit", fault_o, 1);
    chk("R6", "frozen count", scan_cnt_o, 10);
    step(1'b0, 1'b0, 1'b1);
    tag = "R8";
    chk("R8", "fault after clear", fault_o, 0);

    // R2: legal writes including bounds
    tag = "R2";
    wr_lim(50);  chk("R2", "limit 50", limit_o, 50);
    wr_lim(2);   chk("R2", "limit 2", limit_o, 2);
    wr_lim(250); chk("R2", "limit 250", limit_o, 250);
    // R3: clamping
    tag = "R3";
    wr_lim(0);   chk("R3", "clamp 0", limit_o, 2);
    wr_lim(1);   chk("R3", "clamp 1", limit_o, 2);
    wr_lim(251); chk("R3", "clamp 251", limit_o, 250);
    wr_lim(255); chk("R3", "clamp 255", limit_o, 250);

    wr_lim(5);
    step(1'b0, 1'b1, 1'b0);
    // R4: sparse and back-to-back ticks
    tag = "R4";
    step(1'b1, 1'b0, 1'b0); idle(2);
    step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0);
    chk("R4", "count after 3 ticks", scan_cnt_o, 3);
    // R5: boundary together with tick
    tag = "R5";
    step(1'b1, 1'b1, 1'b0);
    chk("R5", "count after boundary+tick", scan_cnt_o, 0);
    // R9: scans ending one tick short never trip
    tag = "R9";
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0);
    end
    chk("R9", "no fault short scans", fault_o, 0);
    // R6: reach the limit
    tag = "R6";
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
    chk("R6", "count at limit", scan_cnt_o, 5);
    step(1'b1, 1'b0, 1'b0);
    chk("R6", "fault raised", fault_o, 1);
    chk("R6", "code", fault_code_o, 32'h22);
    // R7: sticky and frozen
    tag = "R7";
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
    chk("R7", "held count", scan_cnt_o, 5);
    step(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0);
    chk("R7", "count stays 0 under fault", scan_cnt_o, 0);
    chk("R7", "fault sticky", fault_o, 1);
    // R8: clear against a same-cycle trip
    tag = "R8";
    step(1'b0, 1'b0, 1'b1);
    wr_lim(2);
    step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0);
    chk("R8", "count at limit 2", scan_cnt_o, 2);
    step(1'b0, 1'b0, 1'b1);
    chk("R8", "clear wins over trip", fault_o, 0);
    chk("R8", "count cleared", scan_cnt_o, 0);
    idle(4);
    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule